// File: doc/BRIEF.md
# Deferred Store Sequencer for Dual-Pot Register Bank

This block holds the stored settings of two digitally controlled potentiometers: four 6-bit registers per pot, eight in all, standing in for nonvolatile cells. A serial front end, outside this block, decodes each frame and hands over one pulse per completed store command together with its kind, the pot, the register index and the data byte. The sequencer does not write at that point. It records the request and waits for the select line to go inactive. Only that rising edge of `cs_n` starts the commit.

At the commit edge the write-protect input is sampled. When it is high, the registers named by the request are written and a timer keeps the busy flag `wip` raised for a fixed number of clock cycles. The host polls `wip` through its status read. While `wip` is high, new store requests are refused. When protect is low, the request is dropped and `wip` stays low. Register reads go through a combinational port addressed by pot and index.

The controller has three states. `S_IDLE` is empty: it moves to `S_PEND` on a store pulse of a valid kind. `S_PEND` holds a request: a further store pulse replaces it. A select rise with protect high leads to `S_BUSY`, and one with protect low leads back to `S_IDLE`. `S_BUSY` waits for the timer and returns to `S_IDLE` when the timer expires.

Top module: `nv_store_seq`

## Requirements
- R1: After reset `wip` is 0 and all eight registers read 0.
- R2: `rd_data` always shows the register selected by `rd_pot` (0 or 1) and `rd_idx` (0 to 3), with no clock delay.
- R3: A data-write store (`cmd_kind` = 2'b01) puts `cmd_data` into register `cmd_idx` of pot `cmd_pot`. The register keeps its old value until the clock edge that sees `cs_n` go from 0 to 1, and shows the new value from the next cycle on.
- R4: A single wiper store (`cmd_kind` = 2'b10) writes the wiper value of pot `cmd_pot`, taken in the cycle of the command pulse, into register `cmd_idx` of that pot. A later change of the wiper input has no effect on the stored value.
- R5: A global wiper store (`cmd_kind` = 2'b11) writes `wiper0` into pot 0 and `wiper1` into pot 1, both at index `cmd_idx`, in a single commit.
- R6: `wip` rises in the cycle after a commit edge and stays high for exactly WRITE_CYCLES cycles.
- R7: A store command and select rise that arrive while `wip` is high change no register and do not extend or restart `wip`.
- R8: When `wp_n` is 0 at the select rise edge, the pending request is discarded: no register changes and `wip` never rises.
- R9: A select rise with no pending request leaves `wip` low and the registers unchanged. A command pulse with `cmd_kind` = 2'b00 creates no request.
- R10: When two store commands arrive before one select rise, only the later one is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; its rising edge commits |
| wp_n | input | 1 | Write protect, active low, sampled at commit |
| cmd_valid | input | 1 | One-cycle pulse for a complete store command |
| cmd_kind | input | 2 | 01 data write, 10 single wiper store, 11 global wiper store |
| cmd_pot | input | 1 | Target pot for single-pot stores |
| cmd_idx | input | 2 | Register index |
| cmd_data | input | 6 | Data for a data-write store |
| wiper0 | input | 6 | Current wiper position of pot 0 |
| wiper1 | input | 6 | Current wiper position of pot 1 |
| rd_pot | input | 1 | Read pot select |
| rd_idx | input | 2 | Read register index |
| rd_data | output | 6 | Selected register contents |
| wip | output | 1 | Write in progress |

## Verification
A wrong state or a stale pending request shows up one cycle after a select rise. In that case `wip` rises when it should not, or fails to rise, or a register read returns a value that does not match. A timer that is off by one shows up only at the end of the busy window, as a `wip` length other than WRITE_CYCLES. A request captured with the wrong mask or at the wrong moment shows up as a wrong value in the untouched pot or index. The bench therefore reads back neighbours as well as targets.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
    typedef enum logic [1:0] {
        K_NONE   = 2'b00,
        K_WRDATA = 2'b01,
        K_WIPER  = 2'b10,
        K_GLOBAL = 2'b11
    } store_kind_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_PEND = 2'b01,
        S_BUSY = 2'b10
    } seq_state_t;
endpackage

// File: rtl/nv_bank.sv
module nv_bank #(
    parameter int DW   = 6,
    parameter int NREG = 4,
    parameter int NPOT = 2,
    localparam int IW  = $clog2(NREG),
    localparam int PW  = (NPOT > 1) ? $clog2(NPOT) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPOT-1:0]          wr_en,
    input  logic [IW-1:0]            wr_idx,
    input  logic [NPOT-1:0][DW-1:0]  wr_data,
    input  logic [PW-1:0]            rd_pot,
    input  logic [IW-1:0]            rd_idx,
    output logic [DW-1:0]            rd_data
);
    logic [NPOT-1:0][NREG-1:0][DW-1:0] mem;

    for (genvar p = 0; p < NPOT; p++) begin : g_pot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[p] <= '0;
            end else if (wr_en[p]) begin
                mem[p][wr_idx] <= wr_data[p];
            end
        end
    end

    assign rd_data = mem[rd_pot][rd_idx];

    AST_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(|wr_en) |=> $stable(mem)); // R3
endmodule

// File: rtl/wr_timer.sv
module wr_timer #(
    parameter int CYCLES = 40,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic active,
    output logic done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (load) begin
            active <= 1'b1;
            cnt    <= CW'(CYCLES - 1);
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign done = active && (cnt == '0);

    AST_TIMER_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt != '0 && !load) |=> active); // R6
endmodule

// File: rtl/store_fsm.sv
module store_fsm
    import nvseq_pkg::*;
#(
    parameter int DW   = 6,
    parameter int NREG = 4,
    localparam int IW  = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_rise,
    input  logic                 wp_n,
    input  logic                 cmd_valid,
    input  store_kind_t          cmd_kind,
    input  logic                 cmd_pot,
    input  logic [IW-1:0]        cmd_idx,
    input  logic [DW-1:0]        cmd_data,
    input  logic [DW-1:0]        wiper0,
    input  logic [DW-1:0]        wiper1,
    input  logic                 tmr_done,
    output logic                 commit,
    output logic [1:0]           wr_en,
    output logic [IW-1:0]        wr_idx,
    output logic [1:0][DW-1:0]   wr_data
);
    seq_state_t          state, state_nx;
    logic [1:0]          pend_en;
    logic [IW-1:0]       pend_idx;
    logic [1:0][DW-1:0]  pend_data;
    logic                take;

    assign take = cmd_valid && (cmd_kind != K_NONE) && (state != S_BUSY);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (take) state_nx = S_PEND;
            S_PEND: if (cs_rise) state_nx = wp_n ? S_BUSY : S_IDLE;
            S_BUSY: if (tmr_done) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_en   <= '0;
            pend_idx  <= '0;
            pend_data <= '0;
        end else if (take) begin
            pend_idx <= cmd_idx;
            unique case (cmd_kind)
                K_WRDATA: begin
                    pend_en   <= cmd_pot ? 2'b10 : 2'b01;
                    pend_data <= {cmd_data, cmd_data};
                end
                K_WIPER: begin
                    pend_en   <= cmd_pot ? 2'b10 : 2'b01;
                    pend_data <= {wiper1, wiper0};
                end
                K_GLOBAL: begin
                    pend_en   <= 2'b11;
                    pend_data <= {wiper1, wiper0};
                end
                default: pend_en <= '0;
            endcase
        end
    end

    always_comb begin
        commit  = (state == S_PEND) && cs_rise && wp_n;
        wr_en   = commit ? pend_en : 2'b00;
        wr_idx  = pend_idx;
        wr_data = pend_data;
    end

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY && !tmr_done) |=> state == S_BUSY); // R7
    AST_PROTECT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PEND && cs_rise && !wp_n) |=> state == S_IDLE); // R8
endmodule

// File: rtl/nv_store_seq.sv
module nv_store_seq
    import nvseq_pkg::*;
#(
    parameter int DW          = 6,
    parameter int NREG        = 4,
    parameter int WRITE_CYCLES = 40,
    localparam int IW         = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          wp_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_kind,
    input  logic          cmd_pot,
    input  logic [IW-1:0] cmd_idx,
    input  logic [DW-1:0] cmd_data,
    input  logic [DW-1:0] wiper0,
    input  logic [DW-1:0] wiper1,
    input  logic          rd_pot,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic          wip
);
    logic                cs_q, cs_rise;
    logic                commit, tmr_done;
    logic [1:0]          wr_en;
    logic [IW-1:0]       wr_idx;
    logic [1:0][DW-1:0]  wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n;
    end
    assign cs_rise = cs_n && !cs_q;

    store_fsm #(.DW(DW), .NREG(NREG)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .wp_n(wp_n),
        .cmd_valid(cmd_valid), .cmd_kind(store_kind_t'(cmd_kind)),
        .cmd_pot(cmd_pot), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
        .wiper0(wiper0), .wiper1(wiper1), .tmr_done(tmr_done),
        .commit(commit), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    wr_timer #(.CYCLES(WRITE_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(commit), .active(wip), .done(tmr_done)
    );

    nv_bank #(.DW(DW), .NREG(NREG), .NPOT(2)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_pot(rd_pot), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    AST_WIP_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(cs_rise && wp_n)); // R6
    AST_NO_PROTECTED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_en) |-> (wp_n && cs_rise)); // R8
    AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> !(|wr_en)); // R7
endmodule

// File: tb/nv_store_seq_bench.sv
module nv_store_seq_bench;
    localparam int WC = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, wp_n = 1'b1, cmd_valid = 1'b0, cmd_pot = 1'b0;
    logic [1:0] cmd_kind = 2'b00, cmd_idx = 2'b00, rd_idx = 2'b00;
    logic [5:0] cmd_data = '0, wiper0 = '0, wiper1 = '0, rd_data;
    logic       rd_pot = 1'b0, wip;

    int n_cmp = 0, n_bad = 0, in_flight = 0, cyc = 0;

    typedef struct { bit pot; int idx; int val; string req; } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    nv_store_seq #(.WRITE_CYCLES(WC)) u_nv_store_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_pot(cmd_pot),
        .cmd_idx(cmd_idx), .cmd_data(cmd_data), .wiper0(wiper0), .wiper1(wiper1),
        .rd_pot(rd_pot), .rd_idx(rd_idx), .rd_data(rd_data), .wip(wip)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_reg(input bit pot, input int idx, input int val, input string req);
        exp_t e;
        e.pot = pot; e.idx = idx; e.val = val; e.req = req;
        in_flight++;
        sb_q.push_back(e);
    endtask

    task automatic drain();
        wait (in_flight == 0);
    endtask

    // monitor: pops expectations, reads the register port, compares
    initial begin
        forever begin
            exp_t e;
            wait (sb_q.size() > 0);
            e = sb_q.pop_front();
            @(negedge clk);
            rd_pot = e.pot;
            rd_idx = 2'(e.idx);
            #1;
            chk(rd_data == 6'(e.val), e.req, int'(rd_data), e.val);
            in_flight--;
        end
    end

    task automatic send_cmd(input logic [1:0] k, input bit pot, input int idx, input int d);
        @(negedge clk);
        cs_n = 1'b0;
        cmd_valid = 1'b1; cmd_kind = k; cmd_pot = pot;
        cmd_idx = 2'(idx); cmd_data = 6'(d);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_kind = 2'b00;
    endtask

    task automatic end_frame();
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic wip_length(input string req);
        int n = 0;
        @(negedge clk);
        chk(wip == 1'b1, req, int'(wip), 1);
        while (wip) begin n++; @(negedge clk); end
        chk(n == WC, req, n, WC);
    endtask

    task automatic wip_stays_low(input int cycles, input string req);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (wip) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(wip == 1'b0, "R1", int'(wip), 0);
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 4; i++) expect_reg(p[0], i, 0, "R1/R2");
        drain();

        // R3: data write deferred until select rise, then R6 busy length
        send_cmd(2'b01, 1'b0, 2, 6'h2A);
        expect_reg(1'b0, 2, 0, "R3 before rise");
        drain();
        end_frame();
        wip_length("R6");
        expect_reg(1'b0, 2, 6'h2A, "R3");
        expect_reg(1'b1, 2, 0, "R3 other pot");
        drain();

        // R7: store during busy ignored
        send_cmd(2'b01, 1'b1, 0, 6'h15);
        end_frame();
        @(negedge clk);
        chk(wip == 1'b1, "R6 second", int'(wip), 1);
        send_cmd(2'b01, 1'b1, 0, 6'h3F);
        end_frame();
        wait (!wip);
        wip_stays_low(6, "R7 no restart");
        expect_reg(1'b1, 0, 6'h15, "R7");
        drain();

        // R4: wiper captured at command time
        wiper1 = 6'h33;
        send_cmd(2'b10, 1'b1, 3, 0);
        wiper1 = 6'h01;
        end_frame();
        wip_length("R6 wiper");
        expect_reg(1'b1, 3, 6'h33, "R4");
        expect_reg(1'b0, 3, 0, "R4 other pot");
        drain();

        // R5: global store writes both pots
        wiper0 = 6'h3F; wiper1 = 6'h07;
        send_cmd(2'b11, 1'b0, 1, 0);
        end_frame();
        wip_length("R6 global");
        expect_reg(1'b0, 1, 6'h3F, "R5 pot0");
        expect_reg(1'b1, 1, 6'h07, "R5 pot1");
        drain();

        // R8: protect low at rise discards
        wp_n = 1'b0;
        send_cmd(2'b01, 1'b0, 2, 6'h11);
        end_frame();
        wip_stays_low(8, "R8 wip");
        wp_n = 1'b1;
        expect_reg(1'b0, 2, 6'h2A, "R8");
        drain();
        // protect dropped request must not survive into the next frame
        @(negedge clk); cs_n = 1'b0;
        end_frame();
        wip_stays_low(5, "R8 no leftover");

        // R9: kind none and bare select pulse
        send_cmd(2'b00, 1'b0, 0, 6'h22);
        end_frame();
        wip_stays_low(5, "R9");
        expect_reg(1'b0, 0, 0, "R9");
        drain();

        // R10: later command in same frame wins
        send_cmd(2'b01, 1'b0, 0, 6'h05);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = 2'b01; cmd_pot = 1'b1;
        cmd_idx = 2'd1; cmd_data = 6'h0C;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_kind = 2'b00;
        end_frame();
        wip_length("R6 replace");
        expect_reg(1'b1, 1, 6'h0C, "R10");
        expect_reg(1'b0, 0, 0, "R10 first dropped");
        drain();

        finish_run();
    end
endmodule